// File: doc/BRIEF.md
# Split Translation Buffer Invalidate and Sync Controller

This block holds the valid bits of two translation buffers, one for instruction fetches and one for data accesses. Each buffer is two-way set-associative with 64 sets, which gives 128 valid bits per buffer. Software drives the block with three commands: invalidate-entry, synchronize and invalidate-all. Invalidate-entry picks one set from six bits of the effective address and clears both ways of that set in both buffers at once. The translation-enable flags have no effect on it.

Synchronize clears nothing. It holds busy high for as long as an external invalidate-synchronize status input stays active. Invalidate-all is not implemented: issuing it raises a single-cycle illegal-instruction pulse and leaves every valid bit as it was. To empty both buffers, software issues 64 invalidate-entry commands, one for each set index, and then one synchronize. A simple fill port sets single valid bits so that the buffers can be filled for test.

Top module: `tlbq_inval_top`

## Requirements
- R1: The set index of an invalidate-entry command is effAddr[17:12]. All other address bits are ignored.
- R2: Opcode 1 (invalidate-entry) clears valid bits set*2+0 and set*2+1 in both instValid and dataValid at the clock edge that accepts it. All other bits keep their values.
- R3: Invalidate-entry has the same effect for every combination of instXlateOn and dataXlateOn.
- R4: Invalidate-entry finishes in one cycle and never raises busy.
- R5: Opcode 2 (synchronize), accepted while extSyncActive is low, finishes at once with busy staying low and no valid bit changed.
- R6: Synchronize accepted while extSyncActive is high makes busy high from the next cycle. busy stays high while extSyncActive stays high, and falls after the first clock edge at which extSyncActive is sampled low.
- R7: A command presented while busy is high is ignored: it clears no bit and raises no exception.
- R8: Opcode 3 (invalidate-all) makes illegalPulse high for exactly one cycle after the accepting edge and changes no valid bit.
- R9: Opcode 0 is a no-operation and has no visible effect.
- R10: After reset, all 256 valid bits are zero and both busy and illegalPulse are low.
- R11: A fill request (fillSide 0 = instruction, 1 = data) sets bit fillSet*2+fillWay. If an invalidate-entry for the same set is accepted in the same cycle, the invalidate wins and the bit ends up zero.
- R12: 64 invalidate-entry commands with indices 0 to 63, followed by one synchronize, leave both buffers empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | Opcode: 0 no-op, 1 invalidate-entry, 2 synchronize, 3 invalidate-all |
| effAddr | input | 32 | Effective address that supplies the set index |
| instXlateOn | input | 1 | Instruction translation enable (no effect on commands) |
| dataXlateOn | input | 1 | Data translation enable (no effect on commands) |
| extSyncActive | input | 1 | External invalidate-synchronize status |
| fillValid | input | 1 | Test fill strobe |
| fillSide | input | 1 | Fill target: 0 instruction, 1 data |
| fillSet | input | 6 | Fill set index |
| fillWay | input | 1 | Fill way |
| busy | output | 1 | Stall while a synchronize waits |
| illegalPulse | output | 1 | One-cycle illegal-instruction exception |
| instValid | output | 128 | Instruction buffer valid bits, bit set*2+way |
| dataValid | output | 128 | Data buffer valid bits, bit set*2+way |

## Verification
The valid arrays are brought straight out to the ports. A wrong index slice, a skipped buffer or a lost way therefore shows up as a wrong bit pattern in the cycle right after the accepting edge. An error in the control state shows up at busy. A stuck wait state keeps busy high after extSyncActive has dropped. A missing wait state leaves busy low in the cycle after a synchronize that should have stalled. A wrong accept gate shows up as a cleared bit or an exception pulse caused by a command issued while busy was high. Each of these is visible within one clock of the command that causes it.

// File: rtl/tlbq_pkg.sv
package tlbq_pkg;
  localparam int SETS  = 64;
  localparam int SET_W = $clog2(SETS);

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_INVAL   = 2'd1,
    OP_SYNC    = 2'd2,
    OP_ILLEGAL = 2'd3
  } tlbOp_e;

  typedef struct packed {
    logic             invalEn;
    logic [SET_W-1:0] invalSet;
  } tlbStrb_t;
endpackage

// File: rtl/tlbq_ctrl.sv
module tlbq_ctrl
  import tlbq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [SET_W-1:0] cmdIdx,
  input  logic             extSyncActive,
  output tlbStrb_t         strb,
  output logic             busy,
  output logic             illegalPulse
);
  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e stateQ, stateD;
  logic   illegalD;
  logic   accept;
  tlbOp_e op;

  always_comb begin
    op            = tlbOp_e'(cmdOp);
    accept        = cmdValid && (stateQ == ST_IDLE);
    stateD        = stateQ;
    illegalD      = 1'b0;
    strb.invalEn  = accept && (op == OP_INVAL);
    strb.invalSet = cmdIdx;
    case (stateQ)
      ST_IDLE: begin
        if (accept && op == OP_SYNC && extSyncActive) stateD = ST_WAIT;
        if (accept && op == OP_ILLEGAL) illegalD = 1'b1;
      end
      default: begin
        if (!extSyncActive) stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ       <= ST_IDLE;
      illegalPulse <= 1'b0;
    end else begin
      stateQ       <= stateD;
      illegalPulse <= illegalD;
    end
  end

  assign busy = (stateQ == ST_WAIT);
endmodule

// File: rtl/tlbq_valid_array.sv
module tlbq_valid_array
  import tlbq_pkg::*;
#(
  parameter int WAYS    = 2,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int ENTRIES = SETS * WAYS
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrb_t         strb,
  input  logic             fillValid,
  input  logic             fillSide,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  output logic [ENTRIES-1:0] instValid,
  output logic [ENTRIES-1:0] dataValid
);
  logic [ENTRIES-1:0] validQ [2];

  for (genvar side = 0; side < 2; side++) begin : gSide
    logic [ENTRIES-1:0] validD;

    always_comb begin
      validD = validQ[side];
      if (fillValid && (fillSide == side[0]))
        validD[int'(fillSet) * WAYS + int'(fillWay)] = 1'b1;
      if (strb.invalEn) begin
        for (int w = 0; w < WAYS; w++)
          validD[int'(strb.invalSet) * WAYS + w] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) validQ[side] <= '0;
      else       validQ[side] <= validD;
    end
  end

  assign instValid = validQ[0];
  assign dataValid = validQ[1];
endmodule

// File: rtl/tlbq_inval_top.sv
module tlbq_inval_top
  import tlbq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_LSB = 12,
  parameter int WAYS    = 2,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int ENTRIES = SETS * WAYS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [ADDR_W-1:0]  effAddr,
  input  logic               instXlateOn,
  input  logic               dataXlateOn,
  input  logic               extSyncActive,
  input  logic               fillValid,
  input  logic               fillSide,
  input  logic [SET_W-1:0]   fillSet,
  input  logic [WAY_W-1:0]   fillWay,
  output logic               busy,
  output logic               illegalPulse,
  output logic [ENTRIES-1:0] instValid,
  output logic [ENTRIES-1:0] dataValid
);
  tlbStrb_t strb;
  logic     unusedBits;

  // Translation enables and the address bits outside the index do not
  // take part in any command.
  assign unusedBits = ^{effAddr, instXlateOn, dataXlateOn};

  tlbq_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdOp        (cmdOp),
    .cmdIdx       (effAddr[IDX_LSB +: SET_W]),
    .extSyncActive(extSyncActive),
    .strb         (strb),
    .busy         (busy),
    .illegalPulse (illegalPulse)
  );

  tlbq_valid_array #(.WAYS(WAYS)) uArray (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fillValid (fillValid),
    .fillSide  (fillSide),
    .fillSet   (fillSet),
    .fillWay   (fillWay),
    .instValid (instValid),
    .dataValid (dataValid)
  );
endmodule

// File: rtl/tlbq_checker.sv
module tlbq_checker
  import tlbq_pkg::*;
#(
  parameter int WAYS = 2,
  localparam int ENTRIES = SETS * WAYS
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic [1:0]         cmdOp,
  input logic [SET_W-1:0]   effIdx,
  input logic               instXlateOn,
  input logic               dataXlateOn,
  input logic               extSyncActive,
  input logic               fillValid,
  input logic               busy,
  input logic               illegalPulse,
  input logic [ENTRIES-1:0] instValid,
  input logic [ENTRIES-1:0] dataValid
);
  logic             accInval, accSync, accIll;
  logic [SET_W-1:0] lastIdx;

  assign accInval = cmdValid && !busy && (cmdOp == OP_INVAL);
  assign accSync  = cmdValid && !busy && (cmdOp == OP_SYNC);
  assign accIll   = cmdValid && !busy && (cmdOp == OP_ILLEGAL);

  always_ff @(posedge clk) lastIdx <= effIdx;

  // R2: both ways of both buffers are cleared at the chosen set
  a_r2_both_cleared: assert property (@(posedge clk) disable iff (!rstN)
    accInval |=> (instValid[int'(lastIdx) * WAYS +: WAYS] == '0) &&
                 (dataValid[int'(lastIdx) * WAYS +: WAYS] == '0));

  // R3: the clear also happens with translation enabled
  a_r3_ignores_xlate: assert property (@(posedge clk) disable iff (!rstN)
    (accInval && (instXlateOn || dataXlateOn)) |=>
      (dataValid[int'(lastIdx) * WAYS +: WAYS] == '0));

  a_r4_inval_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    accInval |=> !busy);

  a_r5_sync_quick: assert property (@(posedge clk) disable iff (!rstN)
    (accSync && !extSyncActive) |=> !busy);

  a_r6_sync_enter: assert property (@(posedge clk) disable iff (!rstN)
    (accSync && extSyncActive) |=> busy);

  a_r6_sync_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && extSyncActive) |=> busy);

  a_r6_sync_release: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !extSyncActive) |=> !busy);

  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> !illegalPulse);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |=> !illegalPulse);

  a_r8_raises: assert property (@(posedge clk) disable iff (!rstN)
    accIll |=> illegalPulse);

  a_r8_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
    (accIll && !fillValid) |=> ($stable(instValid) && $stable(dataValid)));
endmodule

bind tlbq_inval_top tlbq_checker #(.WAYS(WAYS)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .cmdValid     (cmdValid),
  .cmdOp        (cmdOp),
  .effIdx       (effAddr[IDX_LSB +: tlbq_pkg::SET_W]),
  .instXlateOn  (instXlateOn),
  .dataXlateOn  (dataXlateOn),
  .extSyncActive(extSyncActive),
  .fillValid    (fillValid),
  .busy         (busy),
  .illegalPulse (illegalPulse),
  .instValid    (instValid),
  .dataValid    (dataValid)
);

// File: tb/tb_tlbq_inval_top.sv
`timescale 1ns/1ps
module tb_tlbq_inval_top;
  logic         clk = 1'b0;
  logic         rstN;
  logic         cmdValid;
  logic [1:0]   cmdOp;
  logic [31:0]  effAddr;
  logic         instXlateOn, dataXlateOn, extSyncActive;
  logic         fillValid, fillSide, fillWay;
  logic [5:0]   fillSet;
  logic         busy, illegalPulse;
  logic [127:0] instValid, dataValid;
  logic [127:0] refI, refD;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 1'b0;

  always #10 clk = ~clk;

  tlbq_inval_top dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .effAddr(effAddr), .instXlateOn(instXlateOn), .dataXlateOn(dataXlateOn),
    .extSyncActive(extSyncActive), .fillValid(fillValid), .fillSide(fillSide),
    .fillSet(fillSet), .fillWay(fillWay), .busy(busy),
    .illegalPulse(illegalPulse), .instValid(instValid), .dataValid(dataValid)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] addr;
    logic        iOn;
    logic        dOn;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 32'h0000_3000, 1'b0, 1'b0},
    '{2'd1, 32'hFFFC_0FFF, 1'b1, 1'b1},
    '{2'd0, 32'h0000_5000, 1'b0, 1'b0},
    '{2'd3, 32'h0000_7000, 1'b1, 1'b0},
    '{2'd1, 32'h0003_F000, 1'b1, 1'b0},
    '{2'd1, 32'h0004_A000, 1'b0, 1'b1},
    '{2'd1, 32'h0000_0ABC, 1'b0, 1'b0},
    '{2'd3, 32'h0003_F000, 1'b0, 1'b0},
    '{2'd1, 32'h0002_1FFF, 1'b1, 1'b1},
    '{2'd0, 32'h0000_0000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clearSet(input int s);
    refI[s*2 +: 2] = 2'b00;
    refD[s*2 +: 2] = 2'b00;
  endtask

  task automatic doCmd(input logic [1:0] op, input logic [31:0] addr,
                       input logic iOn, input logic dOn);
    cmdValid = 1'b1; cmdOp = op; effAddr = addr;
    instXlateOn = iOn; dataXlateOn = dOn;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic fillAll();
    for (int side = 0; side < 2; side++) begin
      for (int e = 0; e < 128; e++) begin
        fillValid = 1'b1; fillSide = side[0];
        fillSet = e[6:1]; fillWay = e[0];
        @(posedge clk);
        @(negedge clk);
      end
    end
    fillValid = 1'b0;
    refI = '1; refD = '1;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmdOp = 2'd0; effAddr = '0;
    instXlateOn = 1'b0; dataXlateOn = 1'b0; extSyncActive = 1'b0;
    fillValid = 1'b0; fillSide = 1'b0; fillSet = '0; fillWay = 1'b0;
    refI = '0; refD = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 instValid", instValid, '0);
    chk("R10 dataValid", dataValid, '0);
    chk("R10 busy", {127'd0, busy}, '0);
    chk("R10 illegalPulse", {127'd0, illegalPulse}, '0);

    // R11: fill every bit
    fillAll();
    chk("R11 fill inst", instValid, refI);
    chk("R11 fill data", dataValid, refD);

    // Vector table: R1 R2 R3 R4 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      doCmd(VECS[i].op, VECS[i].addr, VECS[i].iOn, VECS[i].dOn);
      if (VECS[i].op == 2'd1) clearSet(int'(VECS[i].addr[17:12]));
      chk("R1 R2 R3 R9 inst bits", instValid, refI);
      chk("R1 R2 R3 R9 data bits", dataValid, refD);
      chk("R8 illegalPulse", {127'd0, illegalPulse}, {127'd0, VECS[i].op == 2'd3});
      chk("R4 busy", {127'd0, busy}, '0);
    end

    // R5: synchronize with the external signal inactive
    extSyncActive = 1'b0;
    doCmd(2'd2, 32'h0, 1'b0, 1'b0);
    chk("R5 busy", {127'd0, busy}, '0);
    chk("R5 inst bits", instValid, refI);

    // R6 / R7: synchronize that waits, commands ignored meanwhile
    fillAll();
    extSyncActive = 1'b1;
    doCmd(2'd2, 32'h0, 1'b0, 1'b0);
    chk("R6 busy raised", {127'd0, busy}, {127'd0, 1'b1});
    doCmd(2'd1, 32'h0000_5000, 1'b0, 1'b0);
    chk("R7 inval ignored inst", instValid, refI);
    chk("R7 inval ignored data", dataValid, refD);
    doCmd(2'd3, 32'h0, 1'b0, 1'b0);
    chk("R7 illegal ignored", {127'd0, illegalPulse}, '0);
    repeat (3) @(negedge clk);
    chk("R6 busy held", {127'd0, busy}, {127'd0, 1'b1});
    extSyncActive = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R6 busy released", {127'd0, busy}, '0);

    // R11: fill and invalidate collide on set 9, then differ (fill 20, inval 21)
    fillValid = 1'b1; fillSide = 1'b0; fillSet = 6'd9; fillWay = 1'b1;
    doCmd(2'd1, 32'h0000_9000, 1'b0, 1'b0);
    fillValid = 1'b0;
    clearSet(9);
    chk("R11 collision inst", instValid, refI);
    clearSet(20);
    refI = instValid;
    fillValid = 1'b1; fillSide = 1'b1; fillSet = 6'd20; fillWay = 1'b0;
    doCmd(2'd1, 32'h0001_5000, 1'b0, 1'b0);
    fillValid = 1'b0;
    chk("R11 fill beside inval", {127'd0, dataValid[40]}, {127'd0, 1'b1});
    chk("R11 neighbour cleared", {126'd0, dataValid[43:42]}, '0);

    // R12: full sweep
    fillAll();
    for (int s = 0; s < 64; s++) doCmd(2'd1, 32'(s) << 12, 1'b1, 1'b1);
    doCmd(2'd2, 32'h0, 1'b0, 1'b0);
    chk("R12 inst empty", instValid, '0);
    chk("R12 data empty", dataValid, '0);
    chk("R12 busy", {127'd0, busy}, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule